// File: doc/BRIEF.md
# Translation Cache with Flush Control

This block is a small, fully associative cache of finished address translations. It sits in front of a page-table walker. A lookup port takes a virtual address. In the same cycle it reports a hit, the physical address and the page size of the matching entry. A fill port takes the walker's results and stores them. Each entry covers a 4 KiB, 64 KiB or 1 MiB page. The match mask and the way the physical address is built both come from the size stored with the entry.

Software controls the block through a 32-bit register port. One control word enables the cache and carries a self-clearing flush command. A second control word switches a secondary mapping function on or off. Further registers hold the translation-table base, an address-space identifier and a coded first-level table size.

Translation is active only when two conditions hold together: the enable bit is set and the size code is non-zero. The walker reads the table base and the decoded table length from configuration outputs. Changing the table base does not flush the cache by itself. Software must issue a flush before new translations rely on the cache.

Top module: `xlat_cache`

## Requirements
- R1: After reset, every register reads zero and every lookup misses.
- R2: Register offset 0x000 is the control word. Writing bit 0 sets or clears the enable. Bit 1 is a flush command that always reads back as zero, and the other bits read as zero.
- R3: Writing the control word with bits 1 and 0 both set removes every cached entry from the next cycle on, and the cache stays enabled.
- R4: Writing the control word with only bit 1 set removes every cached entry and leaves translation off.
- R5: The size code register at offset 0x018 keeps bits 2:0 and reads them back. `cfg_l1_bytes` equals 16384 shifted right by the code (codes 1 to 7 give 8192 down to 128). A code of 0 gives 0 and keeps translation off, even when the enable bit is set.
- R6: A lookup hits when a valid entry with the current identifier matches the virtual address above the entry's page offset. The page-size codes are 0 for 4 KiB, 1 for 64 KiB and 2 for 1 MiB. The physical address is the stored frame above that offset, joined with the offset taken from the virtual address. `lk_size` gives the entry's code.
- R7: While translation is off, every lookup misses and fills are dropped. A fill with the reserved size code 3 is always dropped.
- R8: Fills go into entries in round-robin order, so the oldest entry is replaced first. A flush returns the pointer to entry 0. When several entries match, the entry with the lowest index wins.
- R9: The identifier register at offset 0x010 keeps its low ASID_W bits. Entries are tagged with the identifier that was current at fill time, and they hit only while that identifier is current.
- R10: The table base register at offset 0x014 keeps bits 31:7 and drives `cfg_base`. Writing it does not flush. Offset 0x004 keeps bit 0, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address, valid when `lk_hit` is high |
| lk_size | output | 2 | Page-size code of the hit entry |
| fill_vld | input | 1 | Fill strobe from the walker |
| fill_va | input | VA_W | Virtual address of the fill |
| fill_pa | input | PA_W | Physical frame of the fill |
| fill_size | input | 2 | Page-size code of the fill |
| cfg_on | output | 1 | Translation active (enable set and size code non-zero) |
| cfg_base | output | 32 | Table base for the walker |
| cfg_l1_bytes | output | 15 | First-level table length in bytes |

## Verification
The bench builds the block with four entries and an 8-bit identifier, using 32-bit virtual and physical addresses. With only four entries, a short run of fills wraps the replacement pointer more than once. That makes eviction order, pointer reset on flush and lowest-index priority between duplicate entries observable at the lookup port. The 32-bit addresses let all three page sizes, including 1 MiB pages near the top of a 2 GiB space, be looked up at their edges.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
   typedef enum logic [1:0] {
      PG_4K   = 2'd0,
      PG_64K  = 2'd1,
      PG_1M   = 2'd2,
      PG_RSVD = 2'd3
   } pg_size_e;

   localparam logic [11:0] OFF_CTRL  = 12'h000;
   localparam logic [11:0] OFF_CTRL2 = 12'h004;
   localparam logic [11:0] OFF_ASID  = 12'h010;
   localparam logic [11:0] OFF_BASE  = 12'h014;
   localparam logic [11:0] OFF_SIZE  = 12'h018;

   localparam int unsigned BASE_LSB  = 7;
   localparam int unsigned MAX_TABLE = 16384;
endpackage

// File: rtl/xlc_regs.sv
module xlc_regs
   import xlc_pkg::*;
#(
   parameter int unsigned ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [11:0]       addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [ASID_W-1:0] asid,
   output logic [31:0]       base,
   output logic [14:0]       l1_bytes,
   output logic              xlat_on,
   output logic              flush
);
   logic              en_q, sec_q;
   logic [ASID_W-1:0] asid_q;
   logic [31:BASE_LSB] base_q;
   logic [2:0]        code_q;

   generate
      if (ASID_W < 1 || ASID_W > 32) begin : g_bad_asid
         $error("xlc_regs: ASID_W must lie in 1..32");
      end
   endgenerate

   wire wr_ctrl = wr && (addr == OFF_CTRL);
   assign flush = wr_ctrl && wdata[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         sec_q  <= 1'b0;
         asid_q <= '0;
         base_q <= '0;
         code_q <= '0;
      end else if (wr) begin
         unique case (addr)
            OFF_CTRL:  en_q   <= wdata[0];
            OFF_CTRL2: sec_q  <= wdata[0];
            OFF_ASID:  asid_q <= wdata[ASID_W-1:0];
            OFF_BASE:  base_q <= wdata[31:BASE_LSB];
            OFF_SIZE:  code_q <= wdata[2:0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         OFF_CTRL:  rdata[0] = en_q;
         OFF_CTRL2: rdata[0] = sec_q;
         OFF_ASID:  rdata[ASID_W-1:0] = asid_q;
         OFF_BASE:  rdata[31:BASE_LSB] = base_q;
         OFF_SIZE:  rdata[2:0] = code_q;
         default:   ;
      endcase
   end

   assign asid     = asid_q;
   assign base     = {base_q, {BASE_LSB{1'b0}}};
   assign l1_bytes = (code_q == 3'd0) ? 15'd0 : 15'(MAX_TABLE >> code_q);
   assign xlat_on  = en_q && (code_q != 3'd0);

   p_code_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFF_SIZE) |=> (l1_bytes == 15'(($past(wdata[2:0]) == 3'd0) ? 0 :
                                                   (MAX_TABLE >> $past(wdata[2:0])))));
   p_both_bits_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[1:0] == 2'b11) |=> rdata[1] == 1'b0 || addr != OFF_CTRL);
   p_flush_only_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[1:0] == 2'b10) |=> !xlat_on);
endmodule

// File: rtl/xlc_store.sv
module xlc_store
   import xlc_pkg::*;
#(
   parameter int unsigned N_ENT  = 8,
   parameter int unsigned VA_W   = 32,
   parameter int unsigned PA_W   = 32,
   parameter int unsigned ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on,
   input  logic              flush,
   input  logic [ASID_W-1:0] asid,
   input  logic [VA_W-1:0]   lk_va,
   output logic              lk_hit,
   output logic [PA_W-1:0]   lk_pa,
   output logic [1:0]        lk_size,
   input  logic              fill_vld,
   input  logic [VA_W-1:0]   fill_va,
   input  logic [PA_W-1:0]   fill_pa,
   input  logic [1:0]        fill_size
);
   localparam int unsigned VPN_W = VA_W - 12;
   localparam int unsigned PPN_W = PA_W - 12;
   localparam int unsigned PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam bit          POW2  = (N_ENT == (1 << PTR_W));

   generate
      if (N_ENT < 2 || N_ENT > 64) begin : g_bad_depth
         $error("xlc_store: N_ENT must lie in 2..64");
      end
      if (VA_W < 21 || PA_W < 21) begin : g_bad_width
         $error("xlc_store: address widths must cover a 1 MiB page");
      end
   endgenerate

   logic [N_ENT-1:0] vld_q;
   logic [VPN_W-1:0] tag_q  [N_ENT];
   logic [PPN_W-1:0] ppn_q  [N_ENT];
   pg_size_e         sz_q   [N_ENT];
   logic [ASID_W-1:0] as_q  [N_ENT];
   logic [PTR_W-1:0] ptr_q, ptr_nxt;
   logic [N_ENT-1:0] match;

   function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
      logic [VPN_W-1:0] m;
      m = '1;
      if (s == PG_64K) m[3:0] = '0;
      else if (s == PG_1M) m[7:0] = '0;
      return m;
   endfunction

   function automatic logic [PA_W-1:0] off_mask(pg_size_e s);
      logic [PA_W-1:0] m;
      m = '0;
      if (s == PG_64K) m[15:0] = '1;
      else if (s == PG_1M) m[19:0] = '1;
      else m[11:0] = '1;
      return m;
   endfunction

   wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:12];

   generate
      for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
         assign match[g] = on && vld_q[g] && (as_q[g] == asid) &&
                           (((tag_q[g] ^ lk_vpn) & vpn_mask(sz_q[g])) == '0);
      end
   endgenerate

   logic [PTR_W-1:0] win;
   always_comb begin
      win = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (match[i]) win = PTR_W'(i);
      end
   end

   logic [PA_W-1:0] frame, omask;
   always_comb begin
      frame   = {ppn_q[win], 12'h000};
      omask   = off_mask(sz_q[win]);
      lk_hit  = |match;
      lk_pa   = (frame & ~omask) | ({{(PA_W-20){1'b0}}, lk_va[19:0]} & omask);
      lk_size = lk_hit ? sz_q[win] : PG_4K;
   end

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == PTR_W'(N_ENT - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   wire fill_ok = on && fill_vld && (fill_size != PG_RSVD);
   wire fill_we = fill_ok && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (fill_we) begin
         vld_q[ptr_q] <= 1'b1;
         ptr_q        <= ptr_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         tag_q[ptr_q] <= fill_va[VA_W-1:12];
         ppn_q[ptr_q] <= fill_pa[PA_W-1:12];
         sz_q[ptr_q]  <= pg_size_e'(fill_size);
         as_q[ptr_q]  <= asid;
      end
   end

   p_off_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !on |-> !lk_hit);
   p_flush_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));
   p_ptr_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ptr_q == '0));
   p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |=> (ptr_q == (($past(ptr_q) == PTR_W'(N_ENT - 1)) ? '0 : $past(ptr_q) + 1'b1)));
   p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |=> vld_q[$past(ptr_q)]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlc_pkg::*;
#(
   parameter int unsigned N_ENT  = 8,
   parameter int unsigned VA_W   = 32,
   parameter int unsigned PA_W   = 32,
   parameter int unsigned ASID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [11:0]     reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic [VA_W-1:0] lk_va,
   output logic            lk_hit,
   output logic [PA_W-1:0] lk_pa,
   output logic [1:0]      lk_size,
   input  logic            fill_vld,
   input  logic [VA_W-1:0] fill_va,
   input  logic [PA_W-1:0] fill_pa,
   input  logic [1:0]      fill_size,
   output logic            cfg_on,
   output logic [31:0]     cfg_base,
   output logic [14:0]     cfg_l1_bytes
);
   logic [ASID_W-1:0] asid;
   logic              flush;

   xlc_regs #(.ASID_W(ASID_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .asid     (asid),
      .base     (cfg_base),
      .l1_bytes (cfg_l1_bytes),
      .xlat_on  (cfg_on),
      .flush    (flush)
   );

   xlc_store #(
      .N_ENT  (N_ENT),
      .VA_W   (VA_W),
      .PA_W   (PA_W),
      .ASID_W (ASID_W)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .on        (cfg_on),
      .flush     (flush),
      .asid      (asid),
      .lk_va     (lk_va),
      .lk_hit    (lk_hit),
      .lk_pa     (lk_pa),
      .lk_size   (lk_size),
      .fill_vld  (fill_vld),
      .fill_va   (fill_va),
      .fill_pa   (fill_pa),
      .fill_size (fill_size)
   );

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!lk_hit && !cfg_on && cfg_base == 32'h0));
endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/100ps
module test_xlat_cache;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] lk_va = '0;
   logic        lk_hit;
   logic [31:0] lk_pa;
   logic [1:0]  lk_size;
   logic        fill_vld = 1'b0;
   logic [31:0] fill_va = '0;
   logic [31:0] fill_pa = '0;
   logic [1:0]  fill_size = '0;
   logic        cfg_on;
   logic [31:0] cfg_base;
   logic [14:0] cfg_l1_bytes;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xlat_cache #(.N_ENT(N), .VA_W(32), .PA_W(32), .ASID_W(8)) i_xlat_cache (.*);

   // behavioural reference state
   bit          m_v [N];
   logic [19:0] m_tag [N];
   logic [19:0] m_ppn [N];
   int          m_sz [N];
   logic [7:0]  m_as [N];
   int          m_ptr;
   bit          m_en, m_sec;
   logic [7:0]  m_asid;
   logic [31:0] m_base;
   logic [2:0]  m_code;

   function automatic bit m_on();
      return m_en && (m_code != 0);
   endfunction

   function automatic int off_bits(int s);
      return (s == 1) ? 16 : (s == 2) ? 20 : 12;
   endfunction

   always @(posedge clk) begin
      bit on_now;
      on_now = m_on();
      if (!rst_n) begin
         foreach (m_v[i]) m_v[i] = 0;
         m_ptr = 0; m_en = 0; m_sec = 0; m_asid = 0; m_base = 0; m_code = 0;
      end else begin
         bit fl;
         fl = reg_wr && reg_addr == 12'h000 && reg_wdata[1];
         if (fl) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_ptr = 0;
         end else if (fill_vld && on_now && fill_size != 2'd3) begin
            m_v[m_ptr] = 1; m_tag[m_ptr] = fill_va[31:12];
            m_ppn[m_ptr] = fill_pa[31:12]; m_sz[m_ptr] = fill_size;
            m_as[m_ptr] = m_asid;
            m_ptr = (m_ptr + 1) % N;
         end
         if (reg_wr) begin
            case (reg_addr)
               12'h000: m_en = reg_wdata[0];
               12'h004: m_sec = reg_wdata[0];
               12'h010: m_asid = reg_wdata[7:0];
               12'h014: m_base = reg_wdata & 32'hFFFF_FF80;
               12'h018: m_code = reg_wdata[2:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_rdata(logic [11:0] a);
      case (a)
         12'h000: return {31'b0, m_en};
         12'h004: return {31'b0, m_sec};
         12'h010: return {24'b0, m_asid};
         12'h014: return m_base;
         12'h018: return {29'b0, m_code};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int w;
         logic [31:0] epa;
         w = -1;
         if (m_on()) begin
            for (int i = N - 1; i >= 0; i--) begin
               int ob;
               ob = off_bits(m_sz[i]) - 12;
               if (m_v[i] && m_as[i] == m_asid &&
                   ((m_tag[i] >> ob) == (lk_va[31:12] >> ob))) w = i;
            end
         end
         check("R6 model hit", {31'b0, lk_hit}, {31'b0, w >= 0});
         if (w >= 0) begin
            int ob;
            ob = off_bits(m_sz[w]);
            epa = (({m_ppn[w], 12'h000} >> ob) << ob) | (lk_va & ((32'h1 << ob) - 1));
            check("R6 model pa", lk_pa, epa);
            check("R6 model size", {30'b0, lk_size}, m_sz[w]);
         end
         check("R10 model rdata", reg_rdata, m_rdata(reg_addr));
         check("R5 model on", {31'b0, cfg_on}, {31'b0, m_on()});
         check("R5 model len", {17'b0, cfg_l1_bytes},
               (m_code == 0) ? 0 : (16384 >> m_code));
         check("R10 model base", cfg_base, m_base);
      end
   end

   task automatic wreg(logic [11:0] a, logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 0;
   endtask

   task automatic fill(logic [31:0] va, logic [31:0] pa, logic [1:0] s);
      @(posedge clk); #1;
      fill_vld = 1; fill_va = va; fill_pa = pa; fill_size = s;
      @(posedge clk); #1;
      fill_vld = 0;
   endtask

   task automatic rreg(logic [11:0] a, logic [31:0] exp, string tag);
      reg_addr = a;
      @(negedge clk);
      check(tag, reg_rdata, exp);
      @(posedge clk); #1;
   endtask

   task automatic look(logic [31:0] va, bit h, logic [31:0] pa, logic [1:0] s, string tag);
      lk_va = va;
      @(negedge clk);
      check(tag, {31'b0, lk_hit}, {31'b0, h});
      if (h) begin
         check(tag, lk_pa, pa);
         check(tag, {30'b0, lk_size}, {30'b0, s});
      end
      @(posedge clk); #1;
   endtask

   initial begin
      #500000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rreg(12'h000, 0, "R1 ctrl");
      rreg(12'h004, 0, "R1 ctrl2");
      rreg(12'h018, 0, "R1 size");
      look(32'h0040_1abc, 0, 0, 0, "R1 miss");
      // R5 size code and length
      wreg(12'h018, 32'hFFFF_FFF9);
      rreg(12'h018, 1, "R5 readback");
      check("R5 len 8192", {17'b0, cfg_l1_bytes}, 8192);
      // R7 fill ignored while disabled
      fill(32'h0040_1000, 32'h8000_5000, 0);
      wreg(12'h000, 1);
      look(32'h0040_1abc, 0, 0, 0, "R7 dropped fill");
      // R2 flush bit reads zero
      wreg(12'h000, 3);
      rreg(12'h000, 1, "R2 ctrl");
      // R6 three page sizes
      fill(32'h0040_1000, 32'h8000_5000, 0);
      fill(32'h0051_0000, 32'h9123_0000, 1);
      fill(32'h7ff0_0000, 32'h4000_0000, 2);
      look(32'h0040_1abc, 1, 32'h8000_5abc, 0, "R6 4k");
      look(32'h0040_2abc, 0, 0, 0, "R6 4k neighbour");
      look(32'h0051_fff4, 1, 32'h9123_fff4, 1, "R6 64k");
      look(32'h7ffe_dcba, 1, 32'h400e_dcba, 2, "R6 1m");
      // R9 identifier
      wreg(12'h010, 32'h0000_0105);
      rreg(12'h010, 5, "R9 readback");
      look(32'h0040_1abc, 0, 0, 0, "R9 other id");
      fill(32'h0040_1000, 32'hA000_1000, 0);
      look(32'h0040_1abc, 1, 32'hA000_1abc, 0, "R9 own id");
      wreg(12'h010, 0);
      look(32'h0040_1abc, 1, 32'h8000_5abc, 0, "R9 back");
      // R5 code zero turns off
      wreg(12'h018, 0);
      look(32'h0040_1abc, 0, 0, 0, "R5 code0 miss");
      wreg(12'h018, 3);
      check("R5 len 2048", {17'b0, cfg_l1_bytes}, 2048);
      look(32'h0051_0004, 1, 32'h9123_0004, 1, "R5 code3 hit");
      // R10 base, ctrl2, unmapped
      wreg(12'h014, 32'hFFFF_FFFF);
      rreg(12'h014, 32'hFFFF_FF80, "R10 base");
      check("R10 cfg_base", cfg_base, 32'hFFFF_FF80);
      look(32'h0040_1abc, 1, 32'h8000_5abc, 0, "R10 no auto flush");
      wreg(12'h004, 32'h0000_FFFF);
      rreg(12'h004, 1, "R10 ctrl2");
      rreg(12'h008, 0, "R10 unmapped");
      wreg(12'h000, 32'hFFFF_FFFD);
      rreg(12'h000, 1, "R2 other bits");
      // R3 flush with enable
      wreg(12'h000, 3);
      look(32'h0040_1abc, 0, 0, 0, "R3 cleared");
      rreg(12'h000, 1, "R3 still enabled");
      // R4 flush alone
      fill(32'h0040_1000, 32'h8000_5000, 0);
      wreg(12'h000, 2);
      rreg(12'h000, 0, "R4 disabled");
      check("R4 cfg_on", {31'b0, cfg_on}, 0);
      wreg(12'h000, 1);
      look(32'h0040_1abc, 0, 0, 0, "R4 cleared");
      // R7 reserved size
      fill(32'h0400_0000, 32'h1234_5000, 3);
      look(32'h0400_0010, 0, 0, 0, "R7 reserved size");
      // R8 round robin
      for (int k = 0; k < 5; k++) fill(32'h0100_0000 + (k << 12), 32'h2000_0000 + (k << 12), 0);
      look(32'h0100_0010, 0, 0, 0, "R8 oldest evicted");
      look(32'h0100_1010, 1, 32'h2000_1010, 0, "R8 kept 1");
      look(32'h0100_4010, 1, 32'h2000_4010, 0, "R8 kept 4");
      fill(32'h0100_5000, 32'h2000_5000, 0);
      fill(32'h0100_6000, 32'h2000_6000, 0);
      wreg(12'h000, 3);
      fill(32'h0300_0000, 32'h5000_0000, 0);
      fill(32'h0300_0000, 32'h6000_0000, 0);
      look(32'h0300_0abc, 1, 32'h5000_0abc, 0, "R8 pointer home");
      repeat (3) @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule